// File: doc/BRIEF.md
# SDRAM Periodic Auto-Refresh Timer

This block keeps an SDRAM's contents alive by asking for an auto-refresh at a fixed spacing of clock cycles. A down-counter reloads from a programmed interval value. Each time it runs out, the block raises a refresh request towards the access sequencer. When the sequencer grants the request, the block drives a one-cycle auto-refresh command strobe. It then holds the bus in deselect for a programmable settling window and finally pulses done.

The interval value is the wanted spacing minus one. A setting of 749 therefore gives one refresh every 750 cycles, which is about 15.6 µs at a 48 MHz memory clock and meets a demand of 4096 refreshes per 64 ms. The release value is also offset by one: a code of 3 holds four deselect cycles after the command. The counter keeps running while a request waits for its grant, so a slow grant does not shift later refreshes. A second expiry that comes before the grant is folded into the pending request and flagged. Refresh runs only while the enable input is high.

Top module: `sdram_refresh_timer`

## Requirements
- R1: While reset is high, and in the first cycle after it, `ref_req`, `ref_cmd`, `hold_desel`, `ref_done` and `overrun` are all 0.
- R2: With `ref_en` high, `ref_req` first rises `interval_cfg`+1 cycles after `ref_en` is raised. Further expiries follow every `interval_cfg`+1 cycles.
- R3: The counter keeps running while `ref_req` waits for `ref_grant`. The next request therefore rises `interval_cfg`+1 cycles after the previous one rose, however late the grant came.
- R4: A grant accepted while `ref_req` is high and no refresh window is open drives `ref_cmd` high for exactly one cycle, in the cycle after the grant. `ref_req` is low in that cycle unless a new expiry arrived at the same time.
- R5: Straight after the `ref_cmd` cycle, `hold_desel` is high for `release_cfg`+1 consecutive cycles. During those cycles `ref_cmd` stays low. At most one of `ref_cmd`, `hold_desel` and `ref_done` is high in any cycle.
- R6: `ref_done` is high for one cycle, in the cycle right after the last `hold_desel` cycle.
- R7: While `ref_en` is low, `ref_req` stays low and the counter is held at `interval_cfg`. Lowering `ref_en` drops a pending request in the next cycle. Raising it again restarts the full spacing of R2.
- R8: If the counter runs out again while a request is still waiting, `ref_req` stays high as one single request and `overrun` is high for one cycle.
- R9: `ref_grant` has no effect while `ref_req` is low, or while a window (command, hold or done cycle) is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Enables periodic refresh |
| interval_cfg | input | 12 | Refresh spacing in cycles, minus one |
| release_cfg | input | 4 | Deselect window after the command, minus one |
| ref_grant | input | 1 | Grant from the access sequencer |
| ref_req | output | 1 | Refresh request, held until granted |
| ref_cmd | output | 1 | One-cycle auto-refresh command strobe |
| hold_desel | output | 1 | High while deselect is driven in the release window |
| ref_done | output | 1 | One-cycle end-of-refresh pulse |
| overrun | output | 1 | One-cycle flag: an expiry hit a request that was still pending |

## Verification
After the enable rises, the request is due at the (`interval_cfg`+1)-th falling edge. The command strobe is due one cycle after the grant. The deselect window then covers the next `release_cfg`+1 cycles, and done comes one cycle later. An overrun is due exactly `interval_cfg`+1 cycles after an ungranted request rose. The bench drives inputs just after a falling edge and counts falling edges from that stimulus. It compares each output at exactly the falling edge where the count above places it, so every check looks at a value that settled half a period earlier.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_CMD  = 2'd1,
    WIN_HOLD = 2'd2,
    WIN_DONE = 2'd3
  } win_state_t;
endpackage

// File: rtl/refresh_interval_counter.sv
module refresh_interval_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] reload_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = en && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= reload_val;
    end else if (cnt_q == '0) begin
      cnt_q <= reload_val;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R7: the count is parked at the reload value while refresh is off
  assert_park_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    (!en && !$past(en) && $stable(reload_val)) |-> (cnt_q == reload_val));
endmodule

// File: rtl/refresh_request_tracker.sv
module refresh_request_tracker (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic expire,
  input  logic accept,
  output logic req,
  output logic overrun
);
  logic req_q;
  logic ovr_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      req_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      ovr_q <= expire && req_q && !accept;
      if (expire) begin
        req_q <= 1'b1;
      end else if (accept) begin
        req_q <= 1'b0;
      end
    end
  end

  assign req     = req_q;
  assign overrun = ovr_q;

  assert_off_drops_req_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !req_q);

  assert_overrun_keeps_req_R8: assert property (@(posedge clk) disable iff (rst)
    ovr_q |-> req_q);
endmodule

// File: rtl/refresh_release_window.sv
module refresh_release_window
  import sdram_refresh_pkg::*;
#(
  parameter int REL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [REL_W-1:0] release_code,
  output logic             busy,
  output logic             cmd,
  output logic             deselect,
  output logic             done
);
  win_state_t       state_q;
  logic [REL_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WIN_IDLE;
      hold_q  <= '0;
    end else begin
      unique case (state_q)
        WIN_IDLE: if (accept) begin
          state_q <= WIN_CMD;
          hold_q  <= release_code;
        end
        WIN_CMD:  state_q <= WIN_HOLD;
        WIN_HOLD: if (hold_q == '0) state_q <= WIN_DONE;
                  else hold_q <= hold_q - 1'b1;
        WIN_DONE: state_q <= WIN_IDLE;
        default:  state_q <= WIN_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != WIN_IDLE);
  assign cmd      = (state_q == WIN_CMD);
  assign deselect = (state_q == WIN_HOLD);
  assign done     = (state_q == WIN_DONE);

  assert_cmd_then_hold_R5: assert property (@(posedge clk) disable iff (rst)
    cmd |=> deselect);

  assert_single_phase_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd, deselect, done}));

  assert_done_after_hold_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(deselect));
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int INTERVAL_W = 12,
  parameter int RELEASE_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ref_en,
  input  logic [INTERVAL_W-1:0] interval_cfg,
  input  logic [RELEASE_W-1:0]  release_cfg,
  input  logic                  ref_grant,
  output logic                  ref_req,
  output logic                  ref_cmd,
  output logic                  hold_desel,
  output logic                  ref_done,
  output logic                  overrun
);
  logic expire;
  logic accept;
  logic win_busy;

  assign accept = ref_req && ref_grant && !win_busy;

  refresh_interval_counter #(.CNT_W(INTERVAL_W)) u_counter (
    .clk        (clk),
    .rst        (rst),
    .en         (ref_en),
    .reload_val (interval_cfg),
    .expire     (expire)
  );

  refresh_request_tracker u_tracker (
    .clk     (clk),
    .rst     (rst),
    .en      (ref_en),
    .expire  (expire),
    .accept  (accept),
    .req     (ref_req),
    .overrun (overrun)
  );

  refresh_release_window #(.REL_W(RELEASE_W)) u_window (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept),
    .release_code (release_cfg),
    .busy         (win_busy),
    .cmd          (ref_cmd),
    .deselect     (hold_desel),
    .done         (ref_done)
  );

  assert_cmd_needs_grant_R4: assert property (@(posedge clk) disable iff (rst)
    ref_cmd |-> $past(ref_req && ref_grant));

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> !(ref_req || ref_cmd || hold_desel || ref_done || overrun));
endmodule

// File: tb/test_sdram_refresh_timer.sv
`timescale 1ns/1ps
module test_sdram_refresh_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_en = 1'b0;
  logic [11:0] interval_cfg = 12'd5;
  logic [3:0]  release_cfg = 4'd0;
  logic        ref_grant = 1'b0;
  logic        ref_req, ref_cmd, hold_desel, ref_done, overrun;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #2.5 clk = ~clk;

  sdram_refresh_timer i_sdram_refresh_timer (
    .clk(clk), .rst(rst), .ref_en(ref_en), .interval_cfg(interval_cfg),
    .release_cfg(release_cfg), .ref_grant(ref_grant), .ref_req(ref_req),
    .ref_cmd(ref_cmd), .hold_desel(hold_desel), .ref_done(ref_done),
    .overrun(overrun)
  );

  // {interval, release code, expected first-request delay, expected hold length}
  localparam logic [43:0] VEC [5] = '{
    {12'd5,   4'd0,  16'd6,   12'd1},
    {12'd9,   4'd3,  16'd10,  12'd4},
    {12'd20,  4'd7,  16'd21,  12'd8},
    {12'd749, 4'd3,  16'd750, 12'd4},
    {12'd30,  4'd15, 16'd31,  12'd16}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_req(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ref_req && n < 5000);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    int t;
    repeat (3) @(negedge clk);
    check(!ref_req && !ref_cmd && !hold_desel && !ref_done && !overrun,
          "R1 reset outputs", {ref_req, ref_cmd, hold_desel, ref_done, overrun}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!ref_req && !ref_cmd && !hold_desel && !ref_done && !overrun,
          "R1 after reset", {ref_req, ref_cmd, hold_desel, ref_done, overrun}, 0);

    // Vector walk
    for (int v = 0; v < 5; v++) begin
      int iv, hold, first;
      iv    = int'(VEC[v][43:32]);
      first = int'(VEC[v][27:12]);
      hold  = int'(VEC[v][11:0]);
      interval_cfg = VEC[v][43:32];
      release_cfg  = VEC[v][31:28];
      ref_en = 1'b0;
      @(negedge clk);
      ref_en = 1'b1;
      wait_req(n);
      check(n == first, "R2 first request delay", n, first);
      ref_grant = 1'b1;
      @(negedge clk);
      t = 1;
      check(ref_cmd && !ref_req, "R4 command after grant", {ref_cmd, ref_req}, 2);
      ref_grant = 1'b0;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        t++;
        check(hold_desel && !ref_cmd, "R5 deselect window", {hold_desel, ref_cmd}, 2);
      end
      @(negedge clk);
      t++;
      check(ref_done && !hold_desel, "R6 done after window", {ref_done, hold_desel}, 2);
      do begin
        @(negedge clk);
        t++;
      end while (!ref_req && t < 5000);
      check(t == iv + 1, "R2 refresh period", t, iv + 1);
      ref_en = 1'b0;
      @(negedge clk);
      check(!ref_req, "R7 disable drops request", ref_req, 0);
    end

    // R3: late grant does not shift the next request
    interval_cfg = 12'd10;
    release_cfg  = 4'd1;
    ref_en = 1'b1;
    wait_req(n);
    t = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      t++;
      check(ref_req && !ref_cmd, "R3 request waits for grant", {ref_req, ref_cmd}, 2);
    end
    ref_grant = 1'b1;
    @(negedge clk);
    t++;
    check(ref_cmd, "R4 late grant command", ref_cmd, 1);
    ref_grant = 1'b0;
    do begin
      @(negedge clk);
      t++;
    end while (!ref_req && t < 5000);
    check(t == 11, "R3 spacing with late grant", t, 11);
    ref_en = 1'b0;
    @(negedge clk);

    // R8: second expiry while pending
    interval_cfg = 12'd4;
    ref_en = 1'b1;
    wait_req(n);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check(ref_req, "R8 single request held", ref_req, 1);
      check(overrun == (k == 5), "R8 overrun pulse", overrun, (k == 5) ? 1 : 0);
    end

    // R7: disable drops pending request, holds off, reloads on re-enable
    ref_en = 1'b0;
    @(negedge clk);
    check(!ref_req && !overrun, "R7 pending request dropped", {ref_req, overrun}, 0);
    repeat (20) @(negedge clk);
    check(!ref_req, "R7 no request while disabled", ref_req, 0);

    // R9: grant ignored while no request
    ref_grant = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!ref_cmd, "R9 grant without request", ref_cmd, 0);
    end
    ref_grant = 1'b0;
    ref_en = 1'b1;
    wait_req(n);
    check(n == 5, "R7 reload on re-enable", n, 5);
    ref_en = 1'b0;
    @(negedge clk);

    // R9: grant ignored during window even with a new request pending
    interval_cfg = 12'd2;
    release_cfg  = 4'd7;
    ref_en = 1'b1;
    wait_req(n);
    ref_grant = 1'b1;
    @(negedge clk);
    check(ref_cmd, "R4 command with held grant", ref_cmd, 1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(hold_desel && !ref_cmd, "R9 grant ignored in window", {hold_desel, ref_cmd}, 2);
    end
    check(ref_req, "R9 new request pending in window", ref_req, 1);
    @(negedge clk);
    check(ref_done && !ref_cmd, "R9 no command in done cycle", {ref_done, ref_cmd}, 2);
    ref_grant = 1'b0;
    ref_en = 1'b0;
    repeat (12) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule